// File: doc/BRIEF.md
# Expansion Bus Cycle Sequencer

This block runs single 8-bit transfers on a PC-style expansion channel with a 20-bit address. The processor side presents a request: a two-bit cycle kind, an address and, for writes, a data byte. The sequencer then plays out the bus cycle. It raises an address strobe in the first clock and holds the address on the bus. It pulls exactly one active-low command line for the command clocks. It ends with a one-clock `done` pulse that carries the read byte.

Memory transfers take four clocks and port transfers take five. A slow slave can pull the shared ready line low, and each low sample adds one whole clock. A hard cap on the number of such clocks turns a stuck slave into a timeout completion instead of a hung bus. Port cycles put out only the low part of the address.

A DMA hold input lets another master take the channel. While it is high the sequencer releases its address, data and command drivers and does not start a new cycle. The cycle already running keeps its own count.

Top module: `xbus_cycle_seq`

## Requirements
- R1: A memory cycle (kind 00 = memory read, 01 = memory write) with ready held high lasts 4 clocks. Counting from the first clock after the accepting edge, clock 1 carries the address strobe, clocks 2 and 3 carry the command and clock 4 shows `done`. `done` is high for one clock only.
- R2: A port cycle (kind 10 = port read, 11 = port write) with ready held high lasts 5 clocks. Clocks 2 to 4 carry the command and clock 5 shows `done`.
- R3: Ready is sampled at the end of every command clock. Each low sample lengthens the cycle by exactly one clock. For reads, `rdata` at `done` holds the `bus_data_in` value sampled at the edge that ends the last command clock.
- R4: `addr_strobe` is high in the first clock of each cycle and in no other clock. No command line is active while it is high. The cycle address is on `bus_addr` from that clock until `done`.
- R5: The four command outputs are active low, at most one is low at any time, and the one that is low matches the cycle kind: bit 0 of the kind selects write, bit 1 selects port.
- R6: If ready is still low at a sample after 10 earlier low samples in the same cycle, that sample ends the cycle. `done` and `timeout_err` then rise together in the following clock, a read returns all ones, and the whole cycle is 13 clocks for either kind.
- R7: While `dma_hold` is high, `bus_addr_oe` and `bus_data_oe` are low, all command outputs are high, and no new request is accepted. A cycle already in progress resumes its command when the hold drops.
- R8: During port cycles, address bits 10 and above on `bus_addr` are zero.
- R9: During the command clocks of a write cycle, `bus_data_oe` is high and `bus_data_out` equals the write byte. `bus_data_oe` is low in every other clock and during reads.
- R10: After reset the block is idle: `busy`, `done`, `addr_strobe`, `bus_addr_oe` and `bus_data_oe` are low and all command outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when idle and no hold |
| req_type | input | 2 | Cycle kind: 00 mem read, 01 mem write, 10 port read, 11 port write |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read byte, valid with `done` |
| timeout_err | output | 1 | Completion was forced by the ready cap |
| addr_strobe | output | 1 | Address latch strobe, high in the first clock |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | Port read command, active low |
| io_wr_n | output | 1 | Port write command, active low |
| bus_addr | output | 20 | Address onto the channel |
| bus_addr_oe | output | 1 | Address and command driver enable |
| bus_data_out | output | 8 | Write byte onto the channel |
| bus_data_oe | output | 1 | Data driver enable |
| bus_data_in | input | 8 | Data from the channel |
| slot_ready | input | 1 | Shared ready line, low to stretch |
| dma_hold | input | 1 | Another master owns the channel |

## Verification
Wait-state stretching and the DMA hand-off can fall in the same command clock. A slave is holding ready low when the hold rises, so the command is released while the stretch count is still running. The bench raises `dma_hold` for several command clocks in the middle of a stretched read and of a stretched write. It checks that all drivers are off during the hold and that the command returns once the hold drops. The cycle length must still equal the base length plus the number of low ready samples, and the read byte and write drive must be correct. A further run pushes the stretch past the cap with the hold in place, to show that the timeout count is not affected by the hand-off.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   // cycle kind: bit 1 = port space, bit 0 = write
   typedef enum logic [1:0] {
      XC_MEM_RD = 2'b00,
      XC_MEM_WR = 2'b01,
      XC_IO_RD  = 2'b10,
      XC_IO_WR  = 2'b11
   } xcyc_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_CMD  = 2'd2,
      PH_END  = 2'd3
   } xph_e;

   function automatic logic kind_is_io(input xcyc_e k);
      return k[1];
   endfunction

   function automatic logic kind_is_wr(input xcyc_e k);
      return k[0];
   endfunction

endpackage

// File: rtl/xbus_phase_timer.sv
module xbus_phase_timer
   import xbus_pkg::*;
#(
   parameter int MEM_CMD_CLKS = 2,
   parameter int IO_CMD_CLKS  = 3,
   parameter int WAIT_LIMIT   = 10,
   parameter bit WAIT_EN      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_io,
   input  logic rdy,
   output xph_e phase,
   output logic capture,
   output logic expire,
   output logic tmo_flag
);
   localparam int MAX_CMD = (MEM_CMD_CLKS > IO_CMD_CLKS) ? MEM_CMD_CLKS : IO_CMD_CLKS;
   localparam int STEP_W  = (MAX_CMD > 1) ? $clog2(MAX_CMD) : 1;
   localparam int WAIT_W  = $clog2(WAIT_LIMIT + 1);

   generate
      if (MEM_CMD_CLKS < 1) begin : g_bad_mem
         $error("MEM_CMD_CLKS must be at least 1");
      end
      if (IO_CMD_CLKS < 1) begin : g_bad_io
         $error("IO_CMD_CLKS must be at least 1");
      end
      if (WAIT_LIMIT < 1) begin : g_bad_wait
         $error("WAIT_LIMIT must be at least 1");
      end
   endgenerate

   logic rdy_eff;
   generate
      if (WAIT_EN) begin : g_wait
         assign rdy_eff = rdy;
      end else begin : g_nowait
         assign rdy_eff = 1'b1;
      end
   endgenerate

   xph_e              phase_q;
   logic [STEP_W-1:0] step_q;
   logic [WAIT_W-1:0] wait_q;
   logic              tmo_q;
   logic [STEP_W-1:0] last_idx;
   logic              last_step;
   logic              wait_full;

   assign last_idx  = is_io ? STEP_W'(IO_CMD_CLKS - 1) : STEP_W'(MEM_CMD_CLKS - 1);
   assign last_step = (step_q == last_idx);
   assign wait_full = (wait_q == WAIT_W'(WAIT_LIMIT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         step_q  <= '0;
         wait_q  <= '0;
         tmo_q   <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  phase_q <= PH_ADDR;
                  step_q  <= '0;
                  wait_q  <= '0;
                  tmo_q   <= 1'b0;
               end
            end
            PH_ADDR: phase_q <= PH_CMD;
            PH_CMD: begin
               if (!rdy_eff) begin
                  if (wait_full) begin
                     phase_q <= PH_END;
                     tmo_q   <= 1'b1;
                  end else begin
                     wait_q <= wait_q + 1'b1;
                  end
               end else if (last_step) begin
                  phase_q <= PH_END;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase    = phase_q;
   assign capture  = (phase_q == PH_CMD) && rdy_eff && last_step;
   assign expire   = (phase_q == PH_CMD) && !rdy_eff && wait_full;
   assign tmo_flag = tmo_q;

   // R6: the low-sample counter never runs past its cap
   assert_wait_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q <= WAIT_W'(WAIT_LIMIT));

   // R1, R2: completion is only ever entered from a command clock
   assert_end_from_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_END) |-> ($past(phase_q) == PH_CMD));

   // R4: the address clock is always followed by a command clock
   assert_addr_then_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_ADDR) |=> (phase_q == PH_CMD));

endmodule

// File: rtl/xbus_cmd_decode.sv
module xbus_cmd_decode
   import xbus_pkg::*;
#(
   parameter int N_KINDS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_act,
   input  logic               hold,
   input  logic [1:0]         ctype,
   output logic [N_KINDS-1:0] cmd_n
);
   generate
      if (N_KINDS != 4) begin : g_bad_kinds
         $error("N_KINDS must be 4");
      end
      for (genvar i = 0; i < N_KINDS; i++) begin : g_line
         assign cmd_n[i] = ~(cmd_act & ~hold & (ctype == 2'(i)));
      end
   endgenerate

   // R5: never more than one command line low
   assert_single_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cmd_n));

   // R7: hold releases every command line
   assert_hold_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> (&cmd_n));

endmodule

// File: rtl/xbus_addr_path.sv
module xbus_addr_path
   import xbus_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 8,
   parameter int IO_ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xph_e              phase,
   input  xcyc_e             kind,
   input  logic              hold,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] wdata_q,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_addr_oe,
   output logic [DATA_W-1:0] bus_data_out,
   output logic              bus_data_oe
);
   logic [ADDR_W-1:0] io_addr;

   generate
      if (IO_ADDR_W > ADDR_W || IO_ADDR_W < 1) begin : g_bad_io_w
         $error("IO_ADDR_W must lie in 1..ADDR_W");
      end
      if (IO_ADDR_W < ADDR_W) begin : g_io_mask
         assign io_addr = {{(ADDR_W - IO_ADDR_W){1'b0}}, addr_q[IO_ADDR_W-1:0]};
      end else begin : g_io_full
         assign io_addr = addr_q;
      end
   endgenerate

   assign bus_addr     = kind_is_io(kind) ? io_addr : addr_q;
   assign bus_addr_oe  = (phase != PH_IDLE) && !hold;
   assign bus_data_out = wdata_q;
   assign bus_data_oe  = (phase == PH_CMD) && kind_is_wr(kind) && !hold;

   // R9: data is only driven while the address side is also driven
   assert_wdata_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_data_oe |-> bus_addr_oe);

endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
   import xbus_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int DATA_W       = 8,
   parameter int IO_ADDR_W    = 10,
   parameter int MEM_CMD_CLKS = 2,
   parameter int IO_CMD_CLKS  = 3,
   parameter int WAIT_LIMIT   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_type,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              timeout_err,
   output logic              addr_strobe,
   output logic              mem_rd_n,
   output logic              mem_wr_n,
   output logic              io_rd_n,
   output logic              io_wr_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_addr_oe,
   output logic [DATA_W-1:0] bus_data_out,
   output logic              bus_data_oe,
   input  logic [DATA_W-1:0] bus_data_in,
   input  logic              slot_ready,
   input  logic              dma_hold
);
   localparam int N_KINDS = 4;

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W must be positive");
      end
   endgenerate

   xph_e              phase;
   xcyc_e             kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              start;
   logic              capture;
   logic              expire;
   logic              tmo_flag;
   logic [N_KINDS-1:0] cmd_n;

   assign start = req_valid && !dma_hold && (phase == PH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q  <= XC_MEM_RD;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (start) begin
            kind_q  <= xcyc_e'(req_type);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (expire) begin
            rdata_q <= '1;
         end else if (capture && !kind_is_wr(kind_q)) begin
            rdata_q <= bus_data_in;
         end
      end
   end

   xbus_phase_timer #(
      .MEM_CMD_CLKS (MEM_CMD_CLKS),
      .IO_CMD_CLKS  (IO_CMD_CLKS),
      .WAIT_LIMIT   (WAIT_LIMIT),
      .WAIT_EN      (1'b1)
   ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .is_io    (kind_is_io(kind_q)),
      .rdy      (slot_ready),
      .phase    (phase),
      .capture  (capture),
      .expire   (expire),
      .tmo_flag (tmo_flag)
   );

   xbus_cmd_decode #(
      .N_KINDS (N_KINDS)
   ) decode_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_act (phase == PH_CMD),
      .hold    (dma_hold),
      .ctype   (kind_q),
      .cmd_n   (cmd_n)
   );

   xbus_addr_path #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .IO_ADDR_W (IO_ADDR_W)
   ) path_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .phase        (phase),
      .kind         (kind_q),
      .hold         (dma_hold),
      .addr_q       (addr_q),
      .wdata_q      (wdata_q),
      .bus_addr     (bus_addr),
      .bus_addr_oe  (bus_addr_oe),
      .bus_data_out (bus_data_out),
      .bus_data_oe  (bus_data_oe)
   );

   assign mem_rd_n    = cmd_n[0];
   assign mem_wr_n    = cmd_n[1];
   assign io_rd_n     = cmd_n[2];
   assign io_wr_n     = cmd_n[3];
   assign busy        = (phase != PH_IDLE);
   assign done        = (phase == PH_END);
   assign timeout_err = (phase == PH_END) && tmo_flag;
   assign addr_strobe = (phase == PH_ADDR);
   assign rdata       = rdata_q;

   // R1, R2: completion lasts a single clock
   assert_single_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: a timeout is reported only with a completion
   assert_tmo_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> done);

   // R7: hold releases address, data and command drivers
   assert_hold_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dma_hold |-> (!bus_addr_oe && !bus_data_oe && mem_rd_n && mem_wr_n && io_rd_n && io_wr_n));

   // R7: no cycle starts from idle while the hold is up
   assert_hold_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_hold && !busy) |=> !busy);

   // R4: no command overlaps the address strobe
   assert_strobe_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      addr_strobe |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n));

endmodule

// File: tb/xbus_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module xbus_cycle_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [1:0]  req_type;
   logic [19:0] req_addr;
   logic [7:0]  req_wdata;
   logic        busy, done, timeout_err, addr_strobe;
   logic [7:0]  rdata;
   logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
   logic [19:0] bus_addr;
   logic        bus_addr_oe, bus_data_oe;
   logic [7:0]  bus_data_out;
   logic [7:0]  bus_data_in;
   logic        slot_ready;
   logic        dma_hold;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   xbus_cycle_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .rdata(rdata), .timeout_err(timeout_err), .addr_strobe(addr_strobe),
      .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
      .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe), .bus_data_out(bus_data_out),
      .bus_data_oe(bus_data_oe), .bus_data_in(bus_data_in), .slot_ready(slot_ready),
      .dma_hold(dma_hold)
   );

   function automatic logic [3:0] strobes();
      return {io_wr_n, io_rd_n, mem_wr_n, mem_rd_n};
   endfunction

   task automatic chk(input string rq, input string what, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // one full cycle; nwait low ready samples, hold raised on command clocks [hold_at, hold_at+hold_len)
   task automatic run_cycle(input string tag, input logic [1:0] ty, input logic [19:0] ad,
                            input logic [7:0] wd, input logic [7:0] rd, input int nwait,
                            input int hold_at, input int hold_len);
      int len = 0;
      int lows = 0;
      int cmdi = 0;
      int extra_ale = 0;
      int bad_cmd = 0;
      int bad_hold = 0;
      int bad_wr = 0;
      bit fin = 0;
      logic [19:0] exp_ad;
      logic [3:0]  exp_n;
      int exp_len;
      exp_ad  = ty[1] ? (ad & 20'h003FF) : ad;
      exp_n   = ~(4'b0001 << ty);
      exp_len = (nwait > 10) ? 13 : ((ty[1] ? 5 : 4) + nwait);
      @(negedge clk);
      req_valid = 1'b1; req_type = ty; req_addr = ad; req_wdata = wd;
      bus_data_in = rd; slot_ready = 1'b1; dma_hold = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 40 && !fin; k++) begin
         if (k > 0) @(negedge clk);
         len++;
         if (k == 0) begin
            chk("R4", {tag, " strobe in first clock"}, addr_strobe, 1);
            chk("R4", {tag, " address in first clock"}, bus_addr, exp_ad);
            chk("R8", {tag, " upper port bits"}, ty[1] ? (bus_addr >> 10) : 0, 0);
            chk("R4", {tag, " no command with strobe"}, strobes(), 4'hF);
         end else begin
            if (addr_strobe) extra_ale++;
            if (done) begin
               fin = 1;
               dma_hold = 1'b0;
               #1;
               chk(ty[1] ? "R2" : "R1", {tag, " cycle length"}, len, exp_len);
               chk("R6", {tag, " timeout flag"}, timeout_err, nwait > 10);
               if (!ty[0]) chk(nwait > 10 ? "R6" : "R3", {tag, " read byte"}, rdata, nwait > 10 ? 8'hFF : rd);
               chk("R9", {tag, " data released at end"}, bus_data_oe, 0);
            end else begin
               if (cmdi >= hold_at && cmdi < hold_at + hold_len) begin
                  dma_hold = 1'b1;
                  #1;
                  if (strobes() != 4'hF || bus_addr_oe || bus_data_oe) bad_hold++;
               end else begin
                  dma_hold = 1'b0;
                  #1;
                  if (strobes() != exp_n || bus_addr != exp_ad || !bus_addr_oe) bad_cmd++;
                  if (ty[0] && (!bus_data_oe || bus_data_out != wd)) bad_wr++;
                  if (!ty[0] && bus_data_oe) bad_wr++;
               end
               if (lows < nwait) begin
                  slot_ready = 1'b0;
                  lows++;
               end else begin
                  slot_ready = 1'b1;
               end
               cmdi++;
            end
         end
      end
      slot_ready = 1'b1;
      dma_hold = 1'b0;
      chk("R1", {tag, " completion seen"}, fin, 1);
      chk("R4", {tag, " strobe only once"}, extra_ale, 0);
      chk("R5", {tag, " command line matches kind"}, bad_cmd, 0);
      chk("R9", {tag, " write drive"}, bad_wr, 0);
      if (hold_len > 0) chk("R7", {tag, " drivers off during hold"}, bad_hold, 0);
      @(negedge clk);
      chk("R1", {tag, " done single clock"}, done, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; req_valid = 1'b0; req_type = 2'b00; req_addr = '0; req_wdata = '0;
      bus_data_in = '0; slot_ready = 1'b1; dma_hold = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10", "busy after reset", busy, 0);
      chk("R10", "done after reset", done, 0);
      chk("R10", "strobe after reset", addr_strobe, 0);
      chk("R10", "commands after reset", strobes(), 4'hF);
      chk("R10", "drivers after reset", {bus_addr_oe, bus_data_oe}, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_base();
      run_cycle("memrd", 2'b00, 20'hABCDE, 8'h00, 8'h5A, 0, -1, 0);
      run_cycle("memwr", 2'b01, 20'h12345, 8'hC3, 8'h00, 0, -1, 0);
      run_cycle("iord",  2'b10, 20'hFF3F8, 8'h00, 8'hA7, 0, -1, 0);
      run_cycle("iowr",  2'b11, 20'h7FFFF, 8'h3C, 8'h00, 0, -1, 0);
   endtask

   task automatic t_waits();
      run_cycle("memrd w3",  2'b00, 20'h00400, 8'h00, 8'h96, 3, -1, 0);
      run_cycle("iowr w1",   2'b11, 20'h00061, 8'h81, 8'h00, 1, -1, 0);
      run_cycle("iord w10",  2'b10, 20'h003FF, 8'h00, 8'h24, 10, -1, 0);
      run_cycle("memwr w10", 2'b01, 20'hF0000, 8'h11, 8'h00, 10, -1, 0);
   endtask

   task automatic t_timeout();
      run_cycle("iord tmo",  2'b10, 20'h00278, 8'h00, 8'h42, 11, -1, 0);
      run_cycle("memwr tmo", 2'b01, 20'h0B800, 8'h77, 8'h00, 11, -1, 0);
      run_cycle("memrd tmo", 2'b00, 20'h08000, 8'h00, 8'h42, 15, -1, 0);
   endtask

   task automatic t_hold_idle();
      @(negedge clk);
      dma_hold = 1'b1; req_valid = 1'b1; req_type = 2'b00; req_addr = 20'h11111;
      repeat (3) @(negedge clk);
      chk("R7", "no start under hold", busy, 0);
      chk("R7", "no strobe under hold", addr_strobe, 0);
      chk("R7", "commands released under hold", strobes(), 4'hF);
      chk("R7", "address released under hold", bus_addr_oe, 0);
      dma_hold = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R7", "start once hold drops", addr_strobe, 1);
      for (int k = 0; k < 10 && !done; k++) @(negedge clk);
      chk("R1", "held request completes", done, 1);
      @(negedge clk);
   endtask

   task automatic t_hold_mid();
      run_cycle("memrd hold", 2'b00, 20'h2468A, 8'h00, 8'hE1, 4, 1, 3);
      run_cycle("iowr hold",  2'b11, 20'h003F2, 8'h5E, 8'h00, 2, 0, 2);
      run_cycle("iord hold tmo", 2'b10, 20'h00060, 8'h00, 8'h10, 11, 2, 5);
   endtask

   initial begin
      #(20 * 100000);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_base();
      t_waits();
      t_timeout();
      t_hold_idle();
      t_hold_mid();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule